// File: doc/BRIEF.md
# Cross-Core Chunk Consolidation Checker

A core runs each program thread twice. The leading copy cuts its work into chunks and commits them. The trailing copy re-runs each chunk and checks it later. Chunks share data with other cores before they are checked, so a chunk must not be declared good while any remote chunk it read from is still unchecked. This block keeps the dependency bookkeeping for that ordering. For every chunk still in flight, it records which remote cores took data from the chunk and which remote chunk, on which core, supplied data to it. It also keeps, for each remote core, the newest chunk that core is known to have consolidated.

The oldest committed chunk retires in one of three ways. After a signature mismatch it raises a fault that throws away every in-flight chunk. After a signature match, if all its producers are known to be consolidated, it is granted. Otherwise the block asks the first unsatisfied producer core for its consolidated ID and tries again when the reply arrives.

The block keeps the dependency graph free of cycles. A chunk may never be both a supplier and a consumer of remote data. When an event would make it both, the block closes the current chunk itself and records the new dependency in a fresh one. If no slot is free, it refuses the event.

Top module: `dep_consolidator`

## Requirements
- R1: After reset the executing chunk ID is 0 and the last consolidated ID is all ones. The stall, grant, lookup, forced-commit, refusal and fault outputs are all low.
- R2: `commit_i` makes the executing chunk committed and opens a new chunk, so `cur_chunk` rises by one (modulo 2^IDW) on the next cycle. With NSLOT chunks in flight, `master_stall` is high and `commit_i` is ignored.
- R3: The leading-thread events are handled one per cycle, with priority `commit_i` over `resp_valid` over `fwd_valid`. An event that loses the priority has no effect, and this includes the table update a response would make.
- R4: An accepted data response sets the consumer entry for `resp_core` in the executing chunk to `resp_chunk`, replacing any older entry. It also writes `resp_cons` into the consolidated-ID table entry for `resp_core`.
- R5: A response that arrives while the executing chunk already has a producer entry causes a boundary. If a slot is free, `force_commit` is high in that cycle, the chunk is closed and the consumer entry goes into the new chunk. If no slot is free, `nack` is high and nothing is recorded, but the table is still updated.
- R6: A forward hit arrives on the executing chunk while that chunk already holds a consumer entry. If a slot is free, `force_commit` is high, and `fwd_core` is recorded in the new chunk and not in the closed one. If no slot is free, `nack` is high and no chunk records the hit.
- R7: `verify_valid` with `verify_match` low, for an unverified committed oldest chunk, raises `fault` in the same cycle. `fault_cores` then equals the union of the producer sets of all in-flight chunks. On the next cycle only one empty executing chunk remains, with ID `last_cons`+1.
- R8: A matching verification makes the oldest committed chunk verified. If its consumer set is empty, `grant` is high in that same cycle.
- R9: A consumer entry with chunk ID P from core c is satisfied when bit IDW-1 of (table[c] − P) mod 2^IDW is 0. A verified chunk is granted in the first cycle in which every one of its entries is satisfied.
- R10: While a verified oldest chunk has an unsatisfied entry, `lk_req` is high. `lk_core` gives the lowest-numbered unsatisfied core and `lk_chunk` its recorded chunk ID; both are 0 when `lk_req` is low. A lookup reply overwrites the table entry for `lkrep_core`, and it wins over a response for the same core in the same cycle.
- R11: Chunks are granted strictly oldest first, so `grant_chunk` equals `last_cons`+1. After a grant, `last_cons` equals the granted ID.
- R12: A verification is ignored when no committed chunk exists or when the oldest one is already verified. It raises no fault and no grant.
- R13: Bits of `fwd_hit_age` are indexed by age, with 0 being the oldest in-flight chunk. Bits at or above the number of in-flight chunks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | 1 | Leading thread closes the executing chunk |
| fwd_valid | input | 1 | Remote request hit local write signatures |
| fwd_core | input | CW | Requesting core |
| fwd_hit_age | input | NSLOT | Hit per in-flight chunk, by age (0 = oldest) |
| resp_valid | input | 1 | Data response received |
| resp_core | input | CW | Supplying core |
| resp_chunk | input | IDW | Supplying chunk ID |
| resp_cons | input | IDW | Supplier's last consolidated ID |
| verify_valid | input | 1 | Trailing thread finished the oldest committed chunk |
| verify_match | input | 1 | Signatures agree |
| lkrep_valid | input | 1 | Lookup reply |
| lkrep_core | input | CW | Replying core |
| lkrep_cons | input | IDW | Replying core's last consolidated ID |
| cur_chunk | output | IDW | ID of the executing chunk |
| last_cons | output | IDW | Last locally consolidated ID |
| master_stall | output | 1 | All slots in use |
| force_commit | output | 1 | Boundary inserted by the block this cycle |
| nack | output | 1 | Boundary needed but no slot free; event refused |
| grant | output | 1 | Oldest chunk consolidated (reset signatures, log, back up registers) |
| grant_chunk | output | IDW | ID of the granted chunk |
| lk_req | output | 1 | Lookup request |
| lk_core | output | CW | Core to query |
| lk_chunk | output | IDW | Awaited producer chunk ID |
| fault | output | 1 | Signature mismatch; start recovery |
| fault_cores | output | NCORE | Cores that consumed data of discarded chunks |

## Verification
The assertions check, on every cycle, the cycle-to-cycle rules for these cases:
- the executing ID stays unchanged under stall;
- a forced boundary advances the ID;
- a refusal happens only when the slots are full;
- `last_cons` follows a grant;
- a lookup stays steady while no table update arrives;
- the ring is flushed after a fault.

Some behaviour only the bench's scenarios can show. Which consumer entry blocks a grant, and the modulo-wrap satisfaction test, depend on the history of responses. So do the producer sets reported on a fault, the swallowing of lower-priority events, and the refusal of dependencies at full occupancy. The bench's behavioural model follows all of this on every cycle.

// File: rtl/dep_consolidator.sv
module dep_consolidator #(
  parameter int NCORE = 4,
  parameter int NSLOT = 4,
  parameter int IDW   = 4,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic             fwd_valid,
  input  logic [CW-1:0]    fwd_core,
  input  logic [NSLOT-1:0] fwd_hit_age,
  input  logic             resp_valid,
  input  logic [CW-1:0]    resp_core,
  input  logic [IDW-1:0]   resp_chunk,
  input  logic [IDW-1:0]   resp_cons,
  input  logic             verify_valid,
  input  logic             verify_match,
  input  logic             lkrep_valid,
  input  logic [CW-1:0]    lkrep_core,
  input  logic [IDW-1:0]   lkrep_cons,
  output logic [IDW-1:0]   cur_chunk,
  output logic [IDW-1:0]   last_cons,
  output logic             master_stall,
  output logic             force_commit,
  output logic             nack,
  output logic             grant,
  output logic [IDW-1:0]   grant_chunk,
  output logic             lk_req,
  output logic [CW-1:0]    lk_core,
  output logic [IDW-1:0]   lk_chunk,
  output logic             fault,
  output logic [NCORE-1:0] fault_cores
);
  localparam logic [SW:0]    LASTC  = (SW+1)'(NSLOT - 1);
  localparam logic [IDW-1:0] ONE_ID = IDW'(1);

  logic [SW-1:0]    head_ptr;
  logic [SW:0]      ncmt;
  logic [IDW-1:0]   head_id;
  logic             vfy;
  logic [NCORE-1:0] prod_m  [NSLOT];
  logic [NCORE-1:0] cons_v  [NSLOT];
  logic [IDW-1:0]   cons_id [NSLOT][NCORE];
  logic [IDW-1:0]   tbl     [NCORE];

  logic [SW-1:0]    cur_ptr, nxt_ptr, rsl;
  logic [NSLOT-1:0] live, curoh, hit;
  logic [NCORE-1:0] unsat;
  logic             full, do_resp, do_fwd, cur_hit, resp_brk, fwd_brk, brk;
  logic             adv, verify_ok, verified;
  logic [IDW-1:0]   gap;

  assign full         = (ncmt == LASTC);
  assign master_stall = full;
  assign cur_ptr      = head_ptr + ncmt[SW-1:0];
  assign nxt_ptr      = cur_ptr + SW'(1);
  assign cur_chunk    = head_id + IDW'(ncmt);
  assign last_cons    = head_id - ONE_ID;
  assign grant_chunk  = head_id;

  assign do_resp  = resp_valid & ~commit_i;
  assign do_fwd   = fwd_valid & ~commit_i & ~resp_valid;
  assign resp_brk = do_resp & (|prod_m[cur_ptr]);
  assign fwd_brk  = do_fwd & cur_hit & (|cons_v[cur_ptr]);
  assign brk      = resp_brk | fwd_brk;
  assign rsl      = resp_brk ? nxt_ptr : cur_ptr;

  assign verify_ok    = verify_valid & (ncmt != '0) & ~vfy;
  assign fault        = verify_ok & ~verify_match;
  assign verified     = vfy | (verify_ok & verify_match);
  assign grant        = verified & ~(|unsat);
  assign lk_req       = verified & (|unsat);
  assign nack         = brk & full & ~fault;
  assign force_commit = brk & ~full & ~fault;
  assign adv          = ~fault & ((commit_i & ~full) | force_commit);

  always_comb begin
    for (int a = 0; a < NSLOT; a++) begin
      live[a]  = ((SW+1)'(a) <= ncmt);
      curoh[a] = ((SW+1)'(a) == ncmt);
    end
    hit     = fwd_hit_age & live;
    cur_hit = |(fwd_hit_age & curoh);
  end

  always_comb begin
    gap     = '0;
    lk_core = '0;
    lk_chunk = '0;
    fault_cores = '0;
    for (int c = 0; c < NCORE; c++) begin
      gap      = tbl[c] - cons_id[head_ptr][c];
      unsat[c] = (ncmt != '0) & cons_v[head_ptr][c] & gap[IDW-1];
    end
    for (int c = NCORE-1; c >= 0; c--) begin
      if (verified && unsat[c]) begin
        lk_core  = CW'(c);
        lk_chunk = cons_id[head_ptr][c];
      end
    end
    for (int s = 0; s < NSLOT; s++) fault_cores = fault_cores | prod_m[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      ncmt     <= '0;
      head_id  <= '0;
      vfy      <= 1'b0;
      for (int s = 0; s < NSLOT; s++) begin
        prod_m[s] <= '0;
        cons_v[s] <= '0;
        for (int c = 0; c < NCORE; c++) cons_id[s][c] <= '0;
      end
      for (int c = 0; c < NCORE; c++) tbl[c] <= '1;
    end else begin
      if (do_resp)     tbl[resp_core]  <= resp_cons;
      if (lkrep_valid) tbl[lkrep_core] <= lkrep_cons;

      if (do_resp && !nack) begin
        cons_v[rsl][resp_core]  <= 1'b1;
        cons_id[rsl][resp_core] <= resp_chunk;
      end
      if (do_fwd && !nack) begin
        for (int a = 0; a < NSLOT; a++)
          if (hit[a] && !(fwd_brk && curoh[a]))
            prod_m[head_ptr + SW'(a)][fwd_core] <= 1'b1;
        if (fwd_brk) prod_m[nxt_ptr][fwd_core] <= 1'b1;
      end

      ncmt <= ncmt + (SW+1)'(adv) - (SW+1)'(grant);
      vfy  <= verified & ~grant;
      if (grant) begin
        head_ptr         <= head_ptr + SW'(1);
        head_id          <= head_id + ONE_ID;
        prod_m[head_ptr] <= '0;
        cons_v[head_ptr] <= '0;
      end

      if (fault) begin
        ncmt <= '0;
        vfy  <= 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
          prod_m[s] <= '0;
          cons_v[s] <= '0;
        end
      end
    end
  end

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_stall && !fault) |=> cur_chunk == $past(cur_chunk));

  p_force_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    force_commit |=> cur_chunk == $past(cur_chunk) + ONE_ID);

  p_nack_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> master_stall);

  p_fault_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!master_stall && cur_chunk == last_cons + ONE_ID));

  p_lk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lkrep_valid && !(resp_valid && !commit_i)) |=> (lk_req && lk_core == $past(lk_core)));

  p_grant_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> last_cons == $past(grant_chunk));
endmodule

// File: tb/tb_dep_consolidator.sv
module tb_dep_consolidator;
  localparam int NC = 4, NS = 4, IW = 4;

  logic clk = 0, rst_n = 0;
  logic commit_i = 0, fwd_valid = 0, resp_valid = 0, verify_valid = 0, verify_match = 0, lkrep_valid = 0;
  logic [1:0] fwd_core = 0, resp_core = 0, lkrep_core = 0;
  logic [NS-1:0] fwd_hit_age = 0;
  logic [IW-1:0] resp_chunk = 0, resp_cons = 0, lkrep_cons = 0;
  logic [IW-1:0] cur_chunk, last_cons, grant_chunk, lk_chunk;
  logic master_stall, force_commit, nack, grant, lk_req, fault;
  logic [1:0] lk_core;
  logic [NC-1:0] fault_cores;

  dep_consolidator #(.NCORE(NC), .NSLOT(NS), .IDW(IW)) dut (.*);

  always #5 clk = ~clk;

  typedef struct packed { logic [3:0] id; logic [3:0] pv; logic [3:0] cv; logic [3:0][3:0] cid; } ck_t;
  ck_t fl[$];
  logic [3:0] tbl [4];
  logic [3:0] mlast;
  bit mvfy;
  int n_run = 0, n_fail = 0, cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic ck_t fresh(logic [3:0] id);
    ck_t k; k = '0; k.id = id; return k;
  endfunction

  task automatic model();
    ck_t h, cu, k;
    int sz;
    bit full, mc, mr, mf, vok, ef, ver, eg, el, brk, en, efc;
    logic [3:0] un, efco, elch, d;
    logic [1:0] elc;
    sz = fl.size(); full = (sz == NS); cu = fl[sz-1]; h = fl[0];
    mc = commit_i; mr = resp_valid && !commit_i; mf = fwd_valid && !commit_i && !resp_valid;
    vok = verify_valid && sz > 1 && !mvfy;
    ef = vok && !verify_match;
    ver = mvfy || (vok && verify_match);
    un = 0;
    for (int c = 0; c < 4; c++) begin d = tbl[c] - h.cid[c]; un[c] = (sz > 1) && h.cv[c] && d[3]; end
    eg = ver && un == 0; el = ver && un != 0; elc = 0; elch = 0;
    for (int c = 3; c >= 0; c--) if (el && un[c]) begin elc = 2'(c); elch = h.cid[c]; end
    brk = (mr && cu.pv != 0) || (mf && fwd_hit_age[sz-1] && cu.cv != 0);
    en = brk && full && !ef; efc = brk && !full && !ef;
    efco = 0; foreach (fl[i]) efco |= fl[i].pv;
    chk("R2 cur_chunk", cur_chunk, cu.id);
    chk("R2 master_stall", master_stall, full);
    chk("R11 last_cons", last_cons, mlast);
    chk("R5 force_commit", force_commit, efc);
    chk("R6 nack", nack, en);
    chk("R8 grant", grant, eg);
    if (eg) chk("R11 grant_chunk", grant_chunk, h.id);
    chk("R10 lk_req", lk_req, el);
    chk("R10 lk_core", lk_core, elc);
    chk("R4 lk_chunk", lk_chunk, elch);
    chk("R7 fault", fault, ef);
    if (ef) chk("R7 fault_cores", fault_cores, efco);
    if (mr) tbl[resp_core] = resp_cons;
    if (lkrep_valid) tbl[lkrep_core] = lkrep_cons;
    if (ef) begin
      fl.delete(); fl.push_back(fresh(mlast + 4'd1)); mvfy = 0;
    end else begin
      if (mc) begin
        if (!full) fl.push_back(fresh(cu.id + 4'd1));
      end else if (mr && !en) begin
        if (efc) fl.push_back(fresh(cu.id + 4'd1));
        k = fl[fl.size()-1]; k.cv[resp_core] = 1; k.cid[resp_core] = resp_chunk; fl[fl.size()-1] = k;
      end else if (mf && !en) begin
        for (int a = 0; a < sz; a++)
          if (fwd_hit_age[a] && !(efc && a == sz-1)) begin k = fl[a]; k.pv[fwd_core] = 1; fl[a] = k; end
        if (efc) begin k = fresh(cu.id + 4'd1); k.pv[fwd_core] = 1; fl.push_back(k); end
      end
      if (eg) begin mlast = fl[0].id; void'(fl.pop_front()); mvfy = 0; end
      else mvfy = ver;
    end
  endtask

  task automatic clr();
    commit_i = 0; fwd_valid = 0; resp_valid = 0; verify_valid = 0; verify_match = 0; lkrep_valid = 0;
    fwd_hit_age = 0;
  endtask

  task automatic tick();
    #2 model();
    @(negedge clk); cyc++;
    clr();
  endtask

  task automatic do_commit(); commit_i = 1; tick(); endtask
  task automatic do_verify(bit m); verify_valid = 1; verify_match = m; tick(); endtask
  task automatic do_resp(int c, int ch, int cs);
    resp_valid = 1; resp_core = 2'(c); resp_chunk = 4'(ch); resp_cons = 4'(cs);
  endtask
  task automatic do_fwd(int c, logic [3:0] m); fwd_valid = 1; fwd_core = 2'(c); fwd_hit_age = m; endtask
  task automatic do_lk(int c, int cs); lkrep_valid = 1; lkrep_core = 2'(c); lkrep_cons = 4'(cs); tick(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    chk("R1 cur_chunk", cur_chunk, 0);
    chk("R1 last_cons", last_cons, 15);
    chk("R1 stall", master_stall, 0);
    chk("R1 grant", grant, 0);
    chk("R1 lk_req", lk_req, 0);
    chk("R1 fault", fault, 0);
    rst_n = 1;
    fl.push_back(fresh(0)); mlast = 4'hF; mvfy = 0;
    for (int c = 0; c < 4; c++) tbl[c] = 4'hF;

    repeat (3) do_commit();
    chk("R2 three commits", cur_chunk, 3);
    chk("R2 full stall", master_stall, 1);
    do_commit();
    chk("R2 commit ignored when full", cur_chunk, 3);

    verify_valid = 1; verify_match = 1; #1;
    chk("R8 immediate grant", grant, 1);
    chk("R11 oldest first", grant_chunk, 0);
    tick();
    chk("R11 last_cons", last_cons, 0);

    do_resp(2, 5, 3); tick();
    do_commit();
    do_verify(1); do_verify(1);
    verify_valid = 1; verify_match = 1; #1;
    chk("R4 lookup core", lk_core, 2);
    chk("R4 lookup chunk", lk_chunk, 5);
    tick(); tick();
    chk("R10 lookup held", lk_req, 1);
    do_lk(2, 4);
    chk("R9 still unsatisfied", lk_req, 1);
    do_lk(2, 5);
    #1 chk("R9 satisfied after reply", grant, 1);
    tick();

    do_resp(1, 15, 14); tick();
    do_commit();
    do_verify(1);
    chk("R9 wrap unsatisfied", lk_req, 1);
    do_lk(1, 1);
    #1 chk("R9 wrap satisfied", grant, 1);
    tick();

    do_fwd(3, 4'b0001); tick();
    do_resp(0, 2, 2); #1;
    chk("R5 forced boundary", force_commit, 1);
    tick();
    do_fwd(1, 4'b0010); #1;
    chk("R6 forced boundary", force_commit, 1);
    tick();
    do_commit();
    do_fwd(2, 4'b1000); tick();
    do_resp(0, 3, 3); #1;
    chk("R5 refused when full", nack, 1);
    tick();
    verify_valid = 1; verify_match = 0; #1;
    chk("R7 fault", fault, 1);
    chk("R7 fault cores", fault_cores, 4'b1110);
    tick();

    verify_valid = 1; verify_match = 0; #1;
    chk("R12 no committed chunk", fault, 0);
    tick();
    do_fwd(0, 4'b1110); tick();
    do_commit();
    verify_valid = 1; verify_match = 0; #1;
    chk("R13 dead ages ignored", fault_cores, 0);
    tick();

    commit_i = 1; do_resp(0, 9, 0); tick();
    verify_valid = 1; verify_match = 1; #1;
    chk("R3 response swallowed", grant, 1);
    tick();
    verify_valid = 1; verify_match = 0; #1;
    chk("R12 nothing to verify", fault, 0);
    tick();

    for (int i = 0; i < 4000; i++) begin
      commit_i = ($urandom_range(0, 5) == 0);
      resp_valid = ($urandom_range(0, 4) == 0);
      resp_core = 2'($urandom); resp_chunk = 4'($urandom); resp_cons = 4'($urandom);
      fwd_valid = ($urandom_range(0, 3) == 0);
      fwd_core = 2'($urandom); fwd_hit_age = 4'($urandom);
      verify_valid = ($urandom_range(0, 2) == 0);
      verify_match = ($urandom_range(0, 19) != 0);
      lkrep_valid = ($urandom_range(0, 3) == 0);
      lkrep_core = 2'($urandom); lkrep_cons = 4'($urandom);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule